// File: doc/BRIEF.md
# Enable-Driven Channel Sample Unpacker

This block takes a dense stream of sample-interleaved beats, typically written by a DMA engine, and hands the samples out to a row of parallel DAC channel lanes. Software chooses which channels are active through one enable bit per channel. The stream carries samples only for the active channels, packed back to back with no padding. Each consumer request therefore draws (active channels × samples per channel) samples. Input beats are taken at a fractional rate, and samples left over from a beat are kept for later requests.

The input is a valid/ready stream. A beat moves only in a cycle where `s_valid` and `s_ready` are both high. The source may hold `s_valid` high with stable data for as long as `s_ready` is low. `s_ready` depends only on the internal fill level, never on `s_valid` or `rd_en`.

The output side has plain pins: a read strobe from the consumer, a valid pulse, an underflow pulse, and one flat data bus holding every lane. Enables must stay constant while streaming, and changing them needs a reset. Parameters: `NCH` channels (default 4, up to 64), `SPC` samples per channel (default 1), `SW` sample width (default 16) and `BEAT` samples per input beat (default 4).

Top module: `upk_unpacker`

## Requirements
- R1: `s_ready` is high exactly when the number of buffered samples is at most NCH*SPC. A beat is accepted only in a cycle with `s_valid` and `s_ready` both high, and a beat offered while `s_ready` is low is neither stored nor counted.
- R2: If `rd_en` is high and the buffered samples plus those accepted in the same cycle number at least (enabled count × SPC), then `rd_valid` is high for one cycle on the next clock. If `rd_en` is low, both `rd_valid` and `rd_underflow` are low on the next clock.
- R3: If `rd_en` is high and fewer samples than the request needs are available, then `rd_underflow` is high and `rd_valid` low on the next clock. No sample is consumed, and a beat accepted in that cycle is kept.
- R4: Input sample i sits at `s_data[i*SW +: SW]`. Samples are taken oldest first, and within a beat lowest i first. They are dealt to enabled channels in ascending channel index, and within a channel to ascending sample index. Sample s of channel c appears at `rd_data[(c*SPC+s)*SW +: SW]`. The data holds its value between valid pulses.
- R5: Samples left over after a request stay buffered in order and are used before any later input.
- R6: The lanes of disabled channels always read zero.
- R7: A beat accepted in the same cycle as a request counts toward that request, ordered after the samples already buffered.
- R8: A synchronous active-high `rst` empties the buffer. After reset `s_ready` is high, `rd_valid` and `rd_underflow` are low, `rd_data` is zero, and a request made with no beat offered underflows.
- R9: `rd_valid` and `rd_underflow` are never high together.
- R10: With no channel enabled, every request gives `rd_valid` with all-zero data and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_en | input | NCH | Per-channel enable |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take a beat |
| s_data | input | BEAT*SW | Input beat, sample i at bits i*SW |
| rd_en | input | 1 | Consumer request strobe |
| rd_valid | output | 1 | Request served, data updated |
| rd_underflow | output | 1 | Request could not be served |
| rd_data | output | NCH*SPC*SW | All channel lanes, channel-major |

## Verification
Assertions check on every cycle that valid and underflow are exclusive and follow the request by exactly one cycle. They also check that a shortage gives underflow without valid, that disabled lanes stay zero, and that the fill level moves by exactly the accepted beat minus the served request. Only the bench scenarios can show the data itself: which stream sample lands in which lane, that leftovers carry over in order, that a same-cycle beat feeds its request, and how the ready rule throttles a source that holds valid high. The bench keeps a queue model of the stream to show this under several enable patterns, including none enabled.

// File: rtl/upk_pkg.sv
package upk_pkg;
  localparam int MAX_CH = 64;

  // number of set bits in an enable vector
  function automatic int count_ones(input logic [MAX_CH-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < MAX_CH; i++) if (v[i]) n++;
    return n;
  endfunction

  // position of channel j among the enabled channels
  function automatic int rank_below(input logic [MAX_CH-1:0] v, input int j);
    int n;
    n = 0;
    for (int i = 0; i < MAX_CH; i++) if (i < j && v[i]) n++;
    return n;
  endfunction
endpackage

// File: rtl/upk_window.sv
module upk_window #(
  parameter int SW   = 16,
  parameter int BEAT = 4,
  parameter int CAP  = 8,
  parameter int CW   = 4
) (
  input  logic [CAP*SW-1:0]  buf_flat,
  input  logic [CW-1:0]      cnt,
  input  logic               take,
  input  logic [BEAT*SW-1:0] beat,
  input  logic [CW-1:0]      need,
  output logic [CAP*SW-1:0]  win_flat,
  output logic [CW-1:0]      avail,
  output logic               sat,
  output logic [CAP*SW-1:0]  rest_flat,
  output logic [CW-1:0]      rest_cnt
);
  // merged view: buffered samples first, then the incoming beat
  always_comb begin
    win_flat = '0;
    for (int k = 0; k < CAP; k++) begin
      if (k < int'(cnt)) begin
        win_flat[k*SW +: SW] = buf_flat[k*SW +: SW];
      end else if (take) begin
        for (int j = 0; j < BEAT; j++)
          if (k == int'(cnt) + j) win_flat[k*SW +: SW] = beat[j*SW +: SW];
      end
    end
  end

  assign avail    = cnt + (take ? CW'(BEAT) : '0);
  assign sat      = avail >= need;
  assign rest_cnt = avail - need;

  // what remains after a served request, shifted down to slot 0
  always_comb begin
    rest_flat = '0;
    for (int k = 0; k < CAP; k++)
      for (int m = 0; m < CAP; m++)
        if (m == k + int'(need)) rest_flat[k*SW +: SW] = win_flat[m*SW +: SW];
  end
endmodule

// File: rtl/upk_store.sv
module upk_store #(
  parameter int SW      = 16,
  parameter int BEAT    = 4,
  parameter int REQ_MAX = 4,
  parameter int CAP     = 8,
  parameter int CW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CAP*SW-1:0] win_flat,
  input  logic [CW-1:0]     avail,
  input  logic [CAP*SW-1:0] rest_flat,
  input  logic [CW-1:0]     rest_cnt,
  input  logic              consume,
  input  logic              take,
  input  logic [CW-1:0]     need,
  output logic [CAP*SW-1:0] buf_flat,
  output logic [CW-1:0]     cnt,
  output logic              s_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_flat <= '0;
      cnt      <= '0;
    end else if (consume) begin
      buf_flat <= rest_flat;
      cnt      <= rest_cnt;
    end else begin
      buf_flat <= win_flat;
      cnt      <= avail;
    end
  end

  // room for a whole beat on top of the current fill
  assign s_ready = int'(cnt) <= REQ_MAX;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= CAP);

  p_fill_track_r5: assert property (@(posedge clk) disable iff (rst)
    (take || consume) |=> int'(cnt) == $past(int'(cnt))
      + ($past(take) ? BEAT : 0) - ($past(consume) ? $past(int'(need)) : 0));

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!take && !consume) |=> $stable(cnt));
endmodule

// File: rtl/upk_route.sv
module upk_route #(
  parameter int NCH     = 4,
  parameter int SPC     = 1,
  parameter int SW      = 16,
  parameter int REQ_MAX = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        en,
  input  logic [REQ_MAX*SW-1:0] win_flat,
  input  logic                  fire,
  input  logic                  miss,
  output logic                  valid,
  output logic                  under,
  output logic [REQ_MAX*SW-1:0] data
);
  localparam int MC = upk_pkg::MAX_CH;

  logic [MC-1:0]         en_w;
  logic [REQ_MAX*SW-1:0] nxt;

  assign en_w = MC'(en);

  // lane (c,s) takes window slot rank(c)*SPC+s
  always_comb begin
    int r;
    nxt = '0;
    for (int c = 0; c < NCH; c++) begin
      r = upk_pkg::rank_below(en_w, c);
      for (int s = 0; s < SPC; s++)
        if (en[c])
          for (int m = 0; m < REQ_MAX; m++)
            if (m == r*SPC + s) nxt[(c*SPC+s)*SW +: SW] = win_flat[m*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      under <= 1'b0;
      data  <= '0;
    end else begin
      valid <= fire;
      under <= miss;
      if (fire) data <= nxt;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(valid && under));

  for (genvar c = 0; c < NCH; c++) begin : g_lane_chk
    p_zero_lane_r6: assert property (@(posedge clk) disable iff (rst)
      !en[c] |-> data[c*SPC*SW +: SPC*SW] == '0);
  end
endmodule

// File: rtl/upk_unpacker.sv
module upk_unpacker #(
  parameter int NCH  = 4,
  parameter int SPC  = 1,
  parameter int SW   = 16,
  parameter int BEAT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ch_en,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [BEAT*SW-1:0]    s_data,
  input  logic                  rd_en,
  output logic                  rd_valid,
  output logic                  rd_underflow,
  output logic [NCH*SPC*SW-1:0] rd_data
);
  localparam int REQ_MAX = NCH * SPC;
  localparam int CAP     = REQ_MAX + BEAT;
  localparam int CW      = $clog2(CAP + 1);
  localparam int MC      = upk_pkg::MAX_CH;

  logic [CAP*SW-1:0] buf_flat, win_flat, rest_flat;
  logic [CW-1:0]     cnt, avail, rest_cnt, need;
  logic              take, sat, fire, miss;

  always_comb need = CW'(upk_pkg::count_ones(MC'(ch_en)) * SPC);

  assign take = s_valid && s_ready;
  assign fire = rd_en && sat;
  assign miss = rd_en && !sat;

  upk_window #(.SW(SW), .BEAT(BEAT), .CAP(CAP), .CW(CW)) u_win (
    .buf_flat (buf_flat),
    .cnt      (cnt),
    .take     (take),
    .beat     (s_data),
    .need     (need),
    .win_flat (win_flat),
    .avail    (avail),
    .sat      (sat),
    .rest_flat(rest_flat),
    .rest_cnt (rest_cnt)
  );

  upk_store #(.SW(SW), .BEAT(BEAT), .REQ_MAX(REQ_MAX), .CAP(CAP), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .win_flat (win_flat),
    .avail    (avail),
    .rest_flat(rest_flat),
    .rest_cnt (rest_cnt),
    .consume  (fire),
    .take     (take),
    .need     (need),
    .buf_flat (buf_flat),
    .cnt      (cnt),
    .s_ready  (s_ready)
  );

  upk_route #(.NCH(NCH), .SPC(SPC), .SW(SW), .REQ_MAX(REQ_MAX)) u_route (
    .clk     (clk),
    .rst     (rst),
    .en      (ch_en),
    .win_flat(win_flat[REQ_MAX*SW-1:0]),
    .fire    (fire),
    .miss    (miss),
    .valid   (rd_valid),
    .under   (rd_underflow),
    .data    (rd_data)
  );

  p_short_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sat) |=> (rd_underflow && !rd_valid));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && !rd_underflow));
endmodule

// File: tb/sim_upk_unpacker.sv
`timescale 1ns/1ps
module sim_upk_unpacker;
  localparam int NCH = 4, SPC = 2, SW = 16, BEAT = 8;
  localparam int DW = NCH*SPC*SW, BW = BEAT*SW;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] ch_en = '0;
  logic s_valid = 1'b0, rd_en = 1'b0;
  logic [BW-1:0] s_data = '0;
  logic s_ready, rd_valid, rd_underflow;
  logic [DW-1:0] rd_data;

  int n_cmp = 0, n_bad = 0, nxt = 1, ecount = 0;
  int mq[$];

  always #5 clk = ~clk;

  upk_unpacker #(.NCH(NCH), .SPC(SPC), .SW(SW), .BEAT(BEAT)) u0 (
    .clk(clk), .rst(rst), .ch_en(ch_en), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_underflow(rd_underflow), .rd_data(rd_data));

  task automatic chk(input bit ok, input string tag, input logic [127:0] a, input logic [127:0] e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  task automatic do_reset(input logic [NCH-1:0] e);
    @(negedge clk);
    rst = 1'b1; ch_en = e; s_valid = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mq.delete();
    ecount = $countones(e);
  endtask

  // one cycle: drive at negedge, model, check results at the next negedge
  task automatic step(input bit v, input bit rd);
    logic [BW-1:0] bd;
    logic [DW-1:0] ed;
    bit ev, eu, acc;
    int need, got[$];
    chk(s_ready === (mq.size() <= NCH*SPC), "R1 ready", 128'(s_ready), 128'(mq.size() <= NCH*SPC));
    for (int i = 0; i < BEAT; i++) bd[i*SW +: SW] = SW'(nxt + i);
    s_valid = v; s_data = bd; rd_en = rd;
    acc = v && s_ready;
    if (acc) begin
      for (int i = 0; i < BEAT; i++) mq.push_back(nxt + i);
      nxt += BEAT;
    end
    need = ecount * SPC; ev = 0; eu = 0; ed = '0;
    if (rd) begin
      if (mq.size() >= need) begin
        ev = 1;
        for (int i = 0; i < need; i++) got.push_back(mq.pop_front());
        begin
          int r;
          r = 0;
          for (int c = 0; c < NCH; c++)
            if (ch_en[c]) begin
              for (int s = 0; s < SPC; s++) ed[(c*SPC+s)*SW +: SW] = SW'(got[r*SPC+s]);
              r++;
            end
        end
      end else eu = 1;
    end
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0; rd_en = 1'b0;
    chk(rd_valid === ev, "R2 valid", 128'(rd_valid), 128'(ev));
    chk(rd_underflow === eu, "R3 underflow", 128'(rd_underflow), 128'(eu));
    chk(!(rd_valid && rd_underflow), "R9 exclusive", 128'({rd_valid, rd_underflow}), 128'(0));
    if (ev) chk(rd_data === ed, "R4 lane data", 128'(rd_data), 128'(ed));
    for (int c = 0; c < NCH; c++)
      if (!ch_en[c])
        chk(rd_data[c*SPC*SW +: SPC*SW] === '0, "R6 disabled lane",
            128'(rd_data[c*SPC*SW +: SPC*SW]), 128'(0));
  endtask

  task automatic t_reset_state();  // R8
    chk(s_ready === 1'b1, "R8 ready after reset", 128'(s_ready), 128'(1));
    chk(rd_valid === 1'b0 && rd_underflow === 1'b0, "R8 flags after reset",
        128'({rd_valid, rd_underflow}), 128'(0));
    chk(rd_data === '0, "R8 data after reset", 128'(rd_data), 128'(0));
  endtask

  task automatic t_empty_request();  // R3, R8: request with nothing buffered
    step(0, 1);
    step(1, 0);          // beat kept
    step(0, 1);          // now served from it
  endtask

  task automatic t_three_channels();  // R4, R5, R7: 6 samples per request, 8 per beat
    do_reset(4'b0111);
    for (int i = 0; i < 12; i++) step(1, 1);
    for (int i = 0; i < 3; i++) step(0, 1);  // drain leftovers, then underflow
  endtask

  task automatic t_sparse();  // R4, R6
    do_reset(4'b1010);
    for (int i = 0; i < 6; i++) step(1, 1);
    step(0, 0);
    for (int i = 0; i < 4; i++) step(0, 1);
  endtask

  task automatic t_same_cycle();  // R7: empty buffer, beat and request together
    do_reset(4'b1111);
    step(1, 1);
    chk(rd_valid === 1'b1, "R7 same-cycle beat served", 128'(rd_valid), 128'(1));
    step(1, 1);
  endtask

  task automatic t_backpressure();  // R1, R5: hold valid until ready drops
    do_reset(4'b1111);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk(s_ready === 1'b0, "R1 ready low when full", 128'(s_ready), 128'(0));
    for (int i = 0; i < 5; i++) step(1, 1);
  endtask

  task automatic t_zero_enable();  // R10
    do_reset(4'b0000);
    step(0, 1);
    chk(rd_valid === 1'b1 && rd_data === '0, "R10 empty request valid",
        128'(rd_data), 128'(0));
    step(1, 0); step(1, 0);
    step(1, 1);
    step(0, 1);
    chk(s_ready === 1'b0, "R10 nothing consumed", 128'(s_ready), 128'(0));
  endtask

  task automatic t_reset_clears();  // R8 after a full buffer
    do_reset(4'b1111);
    step(1, 0); step(1, 0);
    do_reset(4'b1111);
    t_reset_state();
    step(0, 1);
    chk(rd_underflow === 1'b1, "R8 emptied by reset", 128'(rd_underflow), 128'(1));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired, all requirements incomplete act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset(4'b1111);
    t_reset_state();
    t_empty_request();
    t_three_channels();
    t_sparse();
    t_same_cycle();
    t_backpressure();
    t_zero_enable();
    t_reset_clears();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule